// File: doc/BRIEF.md
# Byte-Bus Fetch/Execute Core with Frame Cycle Budget

This block is a small sequential processor core. It fetches opcode and operand bytes over a byte-wide synchronous read port and keeps five 16-bit register pairs (accumulator/flags, three general-purpose pairs and a stack pointer) next to a 16-bit program counter. Each register pair is written one byte at a time, either its upper or its lower half. The core executes only two kinds of instruction. The first is the no-operation opcode. The second is the family of loads that place a 16-bit immediate into a register pair.

Every retired instruction adds its cost in clock cycles to a running cycle total. When the total reaches or passes a frame budget (70244 cycles by default), the core pulses a frame-complete strobe. The budget is then subtracted from the total instead of clearing it, so any overshoot carries into the next frame. A host system can use the strobe to pace a display refresh against the instruction stream. Any opcode outside the supported set stops the core and raises an error flag, which stays set until reset.

Top module: `byte_core`

## Requirements
- R1: While reset is asserted and after it is released, the program counter, all register pairs, the cycle total, the frame strobe and the illegal flag read zero. The first read issued addresses 0x0000.
- R2: Opcode 0x00 changes no register pair. It advances the program counter by exactly 1 and adds 4 to the cycle total.
- R3: An opcode of the form 00pp0001 (binary) loads a 16-bit immediate into the pair chosen by bits 5:4. The encodings are 00 = BC, 01 = DE, 10 = HL and 11 = SP. The accumulator/flags pair is never written.
- R4: The immediate occupies the two bytes after the opcode, with the less significant byte first. The load leaves the program counter 3 past the opcode's address. The program counter only ever steps by +1.
- R5: A 16-bit immediate load adds 8 to the cycle total. The total only ever changes by +4 or +8, or by those amounts less the frame budget.
- R6: When adding an instruction's cost makes the total equal to or greater than the frame budget, the frame strobe is high for exactly one clock. At that point the total becomes the sum minus the budget, so the overshoot is kept. The total always stays below the budget.
- R7: With memory filled with zeros, the first frame strobe after reset comes with the program counter at 17561 and a cycle total of 0.
- R8: Any other opcode, for example 0x76, 0x41 or 0x03, is not executed. The illegal flag rises and the core stops issuing reads. The program counter and the register pairs stay frozen until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 16 | Byte address of the current read (the program counter) |
| mem_rd | output | 1 | Read request; data is expected on mem_rdata in the next cycle |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| frame_done | output | 1 | One-clock strobe when the frame budget is met or exceeded |
| cycles_o | output | CW (17) | Running cycle total within the current frame |
| illegal | output | 1 | Sticky flag: unsupported opcode seen, core halted |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer pair |
| af_o | output | 16 | Accumulator/flags pair |
| bc_o | output | 16 | BC pair |
| de_o | output | 16 | DE pair |
| hl_o | output | 16 | HL pair |

## Verification
The assertions check on every clock that the program counter moves only by single steps and that the cycle total changes only by legal instruction costs, with or without a wrap. They also check that the total stays below the budget, that the frame strobe lasts one clock and matches a wrap by exactly one cost, and that a halted core stays frozen with its read request low. Only the bench's scenarios can show which pair each bits-5:4 encoding lands in, the little-endian byte order, the carried overshoot values (using a second instance with a 10-cycle budget), and the program-counter value of 17561 at the end of an all-zero frame.

// File: rtl/byte_core_pkg.sv
package byte_core_pkg;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_IMM_LO = 3'd2,
    ST_IMM_HI = 3'd3,
    ST_HALT   = 3'd4
  } core_state_e;

  // index into the register-pair file; values 0..3 match opcode bits 5:4
  typedef enum logic [2:0] {
    PR_BC = 3'd0,
    PR_DE = 3'd1,
    PR_HL = 3'd2,
    PR_SP = 3'd3,
    PR_AF = 3'd4
  } pair_e;

  typedef enum logic [1:0] {
    OPK_NOP  = 2'd0,
    OPK_LD16 = 2'd1,
    OPK_BAD  = 2'd2
  } op_kind_e;

  localparam int unsigned NUM_PAIRS = 5;
  localparam int unsigned COST_NOP  = 4;
  localparam int unsigned COST_LD16 = 8;
  localparam int unsigned COST_MAX  = 8;
  localparam int unsigned COST_W    = 4;

endpackage

// File: rtl/bc_decode.sv
module bc_decode
  import byte_core_pkg::*;
(
  input  logic [7:0] opcode,
  output op_kind_e   kind,
  output pair_e      dst
);

  always_comb begin
    dst = pair_e'({1'b0, opcode[5:4]});
    if (opcode == 8'h00) begin
      kind = OPK_NOP;
    end else if (opcode[7:6] == 2'b00 && opcode[3:0] == 4'h1) begin
      kind = OPK_LD16;
    end else begin
      kind = OPK_BAD;
    end
  end

endmodule

// File: rtl/bc_regfile.sv
module bc_regfile
  import byte_core_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NPAIR = NUM_PAIRS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             sel,
  input  logic                   we_hi,
  input  logic                   we_lo,
  input  logic [7:0]             wbyte,
  input  logic                   pc_inc,
  output logic [AW-1:0]          pc_o,
  output logic [NPAIR-1:0][15:0] pairs_o
);

  logic [AW-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = pc_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_inc) begin
      pc_q <= pc_d;
    end
  end

  assign pc_o = pc_q;

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    logic [15:0] q, d;
    logic        en;

    assign en = (sel == 3'(g)) && (we_hi || we_lo);

    always_comb begin
      d = q;
      if (we_hi) d[15:8] = wbyte;
      if (we_lo) d[7:0]  = wbyte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign pairs_o[g] = q;
  end

endmodule

// File: rtl/bc_cycles.sv
module bc_cycles
  import byte_core_pkg::*;
#(
  parameter int FRAME_CYCLES = 70244,
  parameter int CW           = $clog2(FRAME_CYCLES + COST_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              charge,
  input  logic [COST_W-1:0] cost,
  output logic [CW-1:0]     count_o,
  output logic              frame_o
);

  logic [CW-1:0] count_q, count_d, sum;
  logic          wrap, frame_q, frame_d;

  always_comb begin
    sum     = count_q + CW'(cost);
    wrap    = sum >= CW'(FRAME_CYCLES);
    count_d = wrap ? (sum - CW'(FRAME_CYCLES)) : sum;
    frame_d = charge && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      frame_q <= 1'b0;
    end else begin
      frame_q <= frame_d;
      if (charge) begin
        count_q <= count_d;
      end
    end
  end

  assign count_o = count_q;
  assign frame_o = frame_q;

endmodule

// File: rtl/byte_core.sv
module byte_core
  import byte_core_pkg::*;
#(
  parameter int FRAME_CYCLES = 70244,
  parameter int CW           = $clog2(FRAME_CYCLES + COST_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [15:0]   mem_addr,
  output logic          mem_rd,
  input  logic [7:0]    mem_rdata,
  output logic          frame_done,
  output logic [CW-1:0] cycles_o,
  output logic          illegal,
  output logic [15:0]   pc_o,
  output logic [15:0]   sp_o,
  output logic [15:0]   af_o,
  output logic [15:0]   bc_o,
  output logic [15:0]   de_o,
  output logic [15:0]   hl_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  core_state_e state_q, state_d;
  pair_e       dst_q, dst_d;
  logic        illegal_q, illegal_d;

  op_kind_e    dec_kind;
  pair_e       dec_dst;

  logic        pc_inc, we_hi, we_lo, charge;
  logic [COST_W-1:0] cost;
  logic [15:0] pc;
  logic [NUM_PAIRS-1:0][15:0] pairs;

  bc_decode u_dec (
    .opcode (mem_rdata),
    .kind   (dec_kind),
    .dst    (dec_dst)
  );

  bc_regfile #(
    .AW    (16),
    .NPAIR (NUM_PAIRS)
  ) u_rf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sel     (dst_q),
    .we_hi   (we_hi),
    .we_lo   (we_lo),
    .wbyte   (mem_rdata),
    .pc_inc  (pc_inc),
    .pc_o    (pc),
    .pairs_o (pairs)
  );

  bc_cycles #(
    .FRAME_CYCLES (FRAME_CYCLES),
    .CW           (CW)
  ) u_cyc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .charge  (charge),
    .cost    (cost),
    .count_o (cycles_o),
    .frame_o (frame_done)
  );

  always_comb begin
    state_d   = state_q;
    dst_d     = dst_q;
    illegal_d = illegal_q;
    mem_rd    = 1'b0;
    pc_inc    = 1'b0;
    we_hi     = 1'b0;
    we_lo     = 1'b0;
    charge    = 1'b0;
    cost      = '0;
    unique case (state_q)
      ST_FETCH: begin
        mem_rd  = 1'b1;
        pc_inc  = 1'b1;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        unique case (dec_kind)
          OPK_NOP: begin
            charge  = 1'b1;
            cost    = COST_W'(COST_NOP);
            state_d = ST_FETCH;
          end
          OPK_LD16: begin
            dst_d   = dec_dst;
            mem_rd  = 1'b1;
            pc_inc  = 1'b1;
            state_d = ST_IMM_LO;
          end
          default: begin
            illegal_d = 1'b1;
            state_d   = ST_HALT;
          end
        endcase
      end
      ST_IMM_LO: begin
        we_lo   = 1'b1;
        mem_rd  = 1'b1;
        pc_inc  = 1'b1;
        state_d = ST_IMM_HI;
      end
      ST_IMM_HI: begin
        we_hi   = 1'b1;
        charge  = 1'b1;
        cost    = COST_W'(COST_LD16);
        state_d = ST_FETCH;
      end
      default: begin
        state_d = ST_HALT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= ST_FETCH;
      dst_q     <= PR_BC;
      illegal_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      dst_q     <= dst_d;
      illegal_q <= illegal_d;
    end
  end

  assign mem_addr = pc;
  assign illegal  = illegal_q;
  assign pc_o     = pc;
  assign bc_o     = pairs[PR_BC];
  assign de_o     = pairs[PR_DE];
  assign hl_o     = pairs[PR_HL];
  assign sp_o     = pairs[PR_SP];
  assign af_o     = pairs[PR_AF];

endmodule

// File: rtl/byte_core_chk.sv
module byte_core_chk #(
  parameter int FRAME_CYCLES = 70244,
  parameter int CW           = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   pc_o,
  input logic [15:0]   sp_o,
  input logic [CW-1:0] cycles_o,
  input logic          frame_done,
  input logic          illegal,
  input logic          mem_rd
);

  // R4: program counter never jumps, only single steps
  a_r4_pc_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_o != $past(pc_o)) |-> (pc_o == $past(pc_o) + 16'd1));

  // R5: total moves only by an instruction cost, possibly less the budget
  a_r5_cost_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cycles_o != $past(cycles_o)) |->
      ((32'(cycles_o) == 32'($past(cycles_o)) + 32'd4) ||
       (32'(cycles_o) == 32'($past(cycles_o)) + 32'd8) ||
       (32'(cycles_o) + 32'(FRAME_CYCLES) == 32'($past(cycles_o)) + 32'd4) ||
       (32'(cycles_o) + 32'(FRAME_CYCLES) == 32'($past(cycles_o)) + 32'd8)));

  // R6: total stays below the budget
  a_r6_below_budget: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cycles_o) < 32'(FRAME_CYCLES));

  // R6: strobe lasts exactly one clock
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R6: strobe coincides with a wrap that keeps the overshoot
  a_r6_keeps_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_done) |->
      ((32'(cycles_o) + 32'(FRAME_CYCLES) == 32'($past(cycles_o)) + 32'd4) ||
       (32'(cycles_o) + 32'(FRAME_CYCLES) == 32'($past(cycles_o)) + 32'd8)));

  // R8: halted core is frozen and silent
  a_r8_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> (illegal && !mem_rd && $stable(pc_o) && $stable(sp_o)));

endmodule

bind byte_core byte_core_chk #(
  .FRAME_CYCLES (FRAME_CYCLES),
  .CW           (CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc_o       (pc_o),
  .sp_o       (sp_o),
  .cycles_o   (cycles_o),
  .frame_done (frame_done),
  .illegal    (illegal),
  .mem_rd     (mem_rd)
);

// File: tb/sim_byte_core.sv
module sim_byte_core;

  localparam int CW0 = $clog2(70244 + 8);
  localparam int CW1 = $clog2(10 + 8);

  logic clk;
  logic rst_n;

  logic [7:0] mem [4096];

  logic [15:0] addr0, addr1;
  logic        rd0, rd1;
  logic [7:0]  rdata0, rdata1;
  logic        fr0, fr1, ill0, ill1;
  logic [CW0-1:0] cyc0;
  logic [CW1-1:0] cyc1;
  logic [15:0] pc0, sp0, af0, bc0, de0, hl0;
  logic [15:0] pc1, sp1, af1, bc1, de1, hl1;

  int n_checks;
  int n_fail;
  bit finished;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    rdata0 <= mem[addr0[11:0]];
    rdata1 <= mem[addr1[11:0]];
  end

  byte_core u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(addr0), .mem_rd(rd0),
    .mem_rdata(rdata0), .frame_done(fr0), .cycles_o(cyc0), .illegal(ill0),
    .pc_o(pc0), .sp_o(sp0), .af_o(af0), .bc_o(bc0), .de_o(de0), .hl_o(hl0)
  );

  byte_core #(.FRAME_CYCLES(10)) u1 (
    .clk(clk), .rst_n(rst_n), .mem_addr(addr1), .mem_rd(rd1),
    .mem_rdata(rdata1), .frame_done(fr1), .cycles_o(cyc1), .illegal(ill1),
    .pc_o(pc1), .sp_o(sp1), .af_o(af1), .bc_o(bc1), .de_o(de1), .hl_o(hl1)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_halt0(int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (ill0) break;
    end
  endtask

  task automatic wait_frame0(int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (fr0) break;
    end
  endtask

  task automatic wait_frame1(int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (fr1) break;
    end
  endtask

  task automatic t_reset();
    clear_mem();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "pc in reset", 32'(pc0), 0);
    check("R1", "sp in reset", 32'(sp0), 0);
    check("R1", "bc/de/hl in reset", 32'(bc0 | de0 | hl0 | af0), 0);
    check("R1", "cycles in reset", 32'(cyc0), 0);
    check("R1", "frame strobe in reset", 32'(fr0), 0);
    check("R1", "illegal in reset", 32'(ill0), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "first read address", 32'(addr0), 0);
  endtask

  task automatic t_ld_sp();
    clear_mem();
    mem[0] = 8'h31; mem[1] = 8'hFE; mem[2] = 8'hFF; mem[3] = 8'h76;
    do_reset();
    wait_halt0(100);
    check("R3", "sp after 0x31", 32'(sp0), 32'hFFFE);
    check("R4", "pc: load ends at 3, halt fetch steps to 4", 32'(pc0), 4);
    check("R5", "cycles after one load", 32'(cyc0), 8);
    check("R3", "af untouched", 32'(af0), 0);
  endtask

  task automatic t_ld_pairs();
    clear_mem();
    mem[0] = 8'h01; mem[1] = 8'h34; mem[2]  = 8'h12;
    mem[3] = 8'h11; mem[4] = 8'h78; mem[5]  = 8'h56;
    mem[6] = 8'h21; mem[7] = 8'hBC; mem[8]  = 8'h9A;
    mem[9] = 8'h76;
    do_reset();
    wait_halt0(200);
    check("R3", "bc via bits 00", 32'(bc0), 32'h1234);
    check("R3", "de via bits 01", 32'(de0), 32'h5678);
    check("R4", "hl little-endian via bits 10", 32'(hl0), 32'h9ABC);
    check("R3", "sp untouched", 32'(sp0), 0);
    check("R4", "pc after three loads", 32'(pc0), 10);
    check("R5", "cycles after three loads", 32'(cyc0), 24);
  endtask

  task automatic t_nop();
    clear_mem();
    mem[0] = 8'h01; mem[1] = 8'h22; mem[2] = 8'h11;
    mem[3] = 8'h00; mem[4] = 8'h00; mem[5] = 8'h00; mem[6] = 8'h76;
    do_reset();
    wait_halt0(200);
    check("R2", "bc unchanged by nops", 32'(bc0), 32'h1122);
    check("R2", "pc after load + 3 nops", 32'(pc0), 7);
    check("R2", "cycles 8 + 3*4", 32'(cyc0), 20);
    check("R2", "other pairs untouched", 32'(de0 | hl0 | sp0 | af0), 0);
  endtask

  task automatic t_illegal();
    clear_mem();
    mem[0] = 8'h00; mem[1] = 8'h00; mem[2] = 8'h76;
    mem[3] = 8'h31; mem[4] = 8'hFE; mem[5] = 8'hFF;
    do_reset();
    wait_halt0(100);
    check("R8", "illegal flag on 0x76", 32'(ill0), 1);
    check("R8", "pc stops after 0x76", 32'(pc0), 3);
    repeat (20) @(negedge clk);
    check("R8", "pc frozen while halted", 32'(pc0), 3);
    check("R8", "no reads while halted", 32'(rd0), 0);
    check("R8", "following load not executed", 32'(sp0), 0);
    check("R8", "cycles frozen", 32'(cyc0), 8);
    clear_mem();
    mem[0] = 8'h41;
    do_reset();
    wait_halt0(100);
    check("R8", "0x41 rejected", 32'(ill0), 1);
    check("R8", "0x41 leaves bc alone", 32'(bc0), 0);
    clear_mem();
    mem[0] = 8'h03;
    do_reset();
    wait_halt0(100);
    check("R8", "0x03 rejected", 32'(ill0), 1);
    check("R8", "0x03 pc", 32'(pc0), 1);
  endtask

  task automatic t_zero_frame();
    clear_mem();
    do_reset();
    wait_frame0(40000);
    check("R7", "frame strobe seen", 32'(fr0), 1);
    check("R7", "pc at end of zero frame", 32'(pc0), 17561);
    check("R6", "exact wrap leaves zero", 32'(cyc0), 0);
    @(negedge clk);
    check("R6", "strobe one clock only", 32'(fr0), 0);
  endtask

  task automatic t_overshoot();
    clear_mem();
    mem[0] = 8'h31; mem[1] = 8'hFE; mem[2] = 8'hFF;
    mem[3] = 8'h00; mem[4] = 8'h00; mem[5] = 8'h00; mem[6] = 8'h76;
    do_reset();
    wait_frame1(100);
    check("R6", "small-budget strobe", 32'(fr1), 1);
    check("R6", "overshoot 8+4-10 carried", 32'(cyc1), 2);
    check("R6", "pc at first wrap", 32'(pc1), 4);
    @(negedge clk);
    wait_frame1(100);
    check("R6", "second wrap total 2+4+4-10", 32'(cyc1), 0);
    check("R6", "pc at second wrap", 32'(pc1), 6);
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    t_reset();
    t_ld_sp();
    t_ld_pairs();
    t_nop();
    t_illegal();
    t_overshoot();
    t_zero_frame();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule